// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block takes one active-low interrupt pin from outside the chip and turns it into a pending request for the interrupt priority logic of a small microcontroller. The pin is brought into the core clock domain through a flip-flop chain. A three-state request machine records falling edges and, when level sensitivity is chosen, also low levels. Software uses a 4-bit control/status register to pick the sensitivity, hold the request back from the priority logic, acknowledge a pending request and read the pending flag. The block also watches the CPU read strobe and address bus so that fetching the interrupt vector acknowledges the request without any software action.

The request machine has three states. ST_IDLE means nothing is pending. ST_PEND means a request is pending and has not been acknowledged. ST_HOLD means a request was acknowledged in level mode while the pin was still low.

The transitions are:
- T_SET (ST_IDLE to ST_PEND): a falling edge, or a low level while level mode is on.
- T_ACK_CLR (ST_PEND to ST_IDLE): an acknowledge with no falling edge in the same cycle, in edge mode or with the pin high.
- T_ACK_HOLD (ST_PEND to ST_HOLD): an acknowledge in level mode while the pin is low.
- T_RELEASE (ST_HOLD to ST_IDLE): the pin returns high.
- T_MODE_DROP (ST_HOLD to ST_IDLE): level mode is switched off.
- T_REEDGE (any state to ST_PEND): a falling edge. It takes priority over any acknowledge in the same cycle.
- T_RESET (any state to ST_IDLE): reset.

The synchronized pin level is also given to the CPU for its branch-on-pin-level instructions.

Top module: `ext_irq_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, csr_rdata reads 0 and irq_req is 0. This holds even if the pin is held low through reset, because edges are ignored for the first STAGES+1 clocks after reset is released.
- R2: pin_level is irq_pin_n delayed by two clock edges. A pin change made before edge k appears after edge k+1. pin_level is 1 during reset.
- R3: A falling edge on the pin sets the pending flag after the third edge following the pin change. With the mask clear, irq_req is then 1.
- R4: In edge mode (bit 0 = 0), an acknowledge clears the flag at the edge that samples it, even if the pin stays low. A pin that stays low does not set the flag again.
- R5: Writing csr_wdata with bit 2 = 1 is a software acknowledge. The mask and mode bits still take the written values in the same write, and bit 2 always reads back as 0.
- R6: A cycle with cpu_rd = 1 and cpu_addr equal to 0xFFFA or 0xFFFB acknowledges the request. Other addresses such as 0xFFF9 and 0xFFFC do not, and neither does cpu_rd = 0.
- R7: In level mode (bit 0 = 1), an acknowledge while the pin is low keeps the flag set. The flag clears once the synchronized pin reads 1, which is the third edge after the pin goes high.
- R8: In level mode, the pin returning high without an acknowledge leaves the flag set. A later acknowledge with the pin high clears it.
- R9: After an acknowledge, a new falling edge sets the flag again.
- R10: If an acknowledge and a detected falling edge fall in the same cycle, the flag stays set.
- R11: With mask bit 1 = 1, irq_req is 0, but the flag still sets and reads back as 1. Clearing the mask presents the pending request on irq_req from the next cycle.
- R12: Register layout: bit 3 is the read-only pending flag, bit 2 is the acknowledge bit (reads 0), bit 1 is the mask and bit 0 is the mode. Writes to bit 3 are ignored.
- R13: Switching level mode on while the pin is already low sets the flag one edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous external interrupt pin, active low |
| csr_wr | input | 1 | Write strobe for the control/status register |
| csr_wdata | input | 4 | Write data for the control/status register |
| csr_rdata | output | 4 | Read data {flag, 0, mask, mode} |
| cpu_addr | input | ADDR_W | CPU address bus |
| cpu_rd | input | 1 | CPU read strobe, qualifies the vector fetch |
| irq_req | output | 1 | Masked request to the priority logic |
| pin_level | output | 1 | Synchronized pin level for the branch instructions |

## Verification
The bench drops the pin exactly two cycles before a software acknowledge, so that the edge and the acknowledge meet in the same cycle. A design that lets the clear win would lose that request. In level mode it acknowledges while the pin is still low, then releases the pin. A design without a held-after-acknowledge state would drop the flag too early, and one that ignores the pin would never clear it. It holds the pin low through reset: a chain that is not armed after reset would report a request nobody made. It also probes addresses on both sides of the vector pair, and a fetch address without the read strobe, where a loose decoder would clear a request it should keep.

// File: rtl/eic_pkg.sv
package eic_pkg;

    // State of the pending-request machine
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PEND = 2'd1,
        ST_HOLD = 2'd2
    } req_state_t;

    // Control/status register layout
    localparam int CSR_W    = 4;
    localparam int BIT_MODE = 0;
    localparam int BIT_MASK = 1;
    localparam int BIT_ACK  = 2;
    localparam int BIT_FLAG = 3;

endpackage

// File: rtl/eic_pin_sync.sv
module eic_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic level,
    output logic fall
);

    localparam int                CNT_W  = $clog2(STAGES + 2);
    localparam logic [CNT_W-1:0]  ARM_AT = CNT_W'(STAGES + 1);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    logic [CNT_W-1:0]  fill_q;
    logic              armed;

    // Shift chain, reset to the idle (high) pin level
    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= pin_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], pin_n};
            end
        end
    endgenerate

    // Previous synchronized value and fill counter after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            fill_q <= '0;
        end else begin
            prev_q <= chain_q[STAGES-1];
            if (fill_q != ARM_AT) fill_q <= fill_q + 1'b1;
        end
    end

    assign armed = (fill_q == ARM_AT);
    assign level = chain_q[STAGES-1];
    assign fall  = armed & prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/eic_vec_decode.sv
module eic_vec_decode #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFA
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic              fetch_ack
);

    // The vector is a two-byte pair: ignore the lowest address bit
    localparam logic [ADDR_W-2:0] VEC_PAIR = VEC_ADDR[ADDR_W-1:1];

    always_comb begin
        fetch_ack = cpu_rd && (cpu_addr[ADDR_W-1:1] == VEC_PAIR);
    end

endmodule

// File: rtl/eic_ctrl_reg.sv
module eic_ctrl_reg
    import eic_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    input  logic             flag,
    output logic             mode,
    output logic             mask,
    output logic             soft_ack,
    output logic [CSR_W-1:0] rdata
);

    logic mode_q;
    logic mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            mask_q <= 1'b0;
        end else if (wr_en) begin
            mode_q <= wdata[BIT_MODE];
            mask_q <= wdata[BIT_MASK];
        end
    end

    always_comb begin
        soft_ack         = wr_en & wdata[BIT_ACK];
        rdata            = '0;
        rdata[BIT_FLAG]  = flag;
        rdata[BIT_MASK]  = mask_q;
        rdata[BIT_MODE]  = mode_q;
    end

    assign mode = mode_q;
    assign mask = mask_q;

endmodule

// File: rtl/eic_req_fsm.sv
module eic_req_fsm
    import eic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fall,
    input  logic pin_low,
    input  logic mode,
    input  logic mask,
    input  logic ack,
    output logic flag,
    output logic irq_req
);

    req_state_t state_q;
    req_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state: a falling edge always wins over an acknowledge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (fall || (mode && pin_low)) state_d = ST_PEND;
            end
            ST_PEND: begin
                if (fall)     state_d = ST_PEND;
                else if (ack) state_d = (mode && pin_low) ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (fall)                   state_d = ST_PEND;
                else if (!mode || !pin_low) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        flag    = (state_q != ST_IDLE);
        irq_req = (state_q != ST_IDLE) && !mask;
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eic_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR    = 16'hFFFA,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_pin_n,
    input  logic              csr_wr,
    input  logic [CSR_W-1:0]  csr_wdata,
    output logic [CSR_W-1:0]  csr_rdata,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    output logic              irq_req,
    output logic              pin_level
);

    logic sync_level;
    logic pin_fall;
    logic fetch_ack;
    logic soft_ack;
    logic ack_any;
    logic mode_q;
    logic mask_q;
    logic flag;

    eic_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (irq_pin_n),
        .level (sync_level),
        .fall  (pin_fall)
    );

    eic_vec_decode #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_vec (
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .fetch_ack (fetch_ack)
    );

    eic_ctrl_reg u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (csr_wr),
        .wdata    (csr_wdata),
        .flag     (flag),
        .mode     (mode_q),
        .mask     (mask_q),
        .soft_ack (soft_ack),
        .rdata    (csr_rdata)
    );

    assign ack_any = fetch_ack | soft_ack;

    eic_req_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall    (pin_fall),
        .pin_low (~sync_level),
        .mode    (mode_q),
        .mask    (mask_q),
        .ack     (ack_any),
        .flag    (flag),
        .irq_req (irq_req)
    );

    assign pin_level = sync_level;

endmodule

// File: rtl/eic_checker.sv
module eic_checker #(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFA
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        csr_rdata,
    input logic              irq_req,
    input logic              pin_level,
    input logic              mode,
    input logic              ack_any,
    input logic              fall,
    input logic              cpu_rd,
    input logic [ADDR_W-1:0] cpu_addr
);

    logic vec_hit;
    assign vec_hit = cpu_rd && ((cpu_addr == VEC_ADDR) || (cpu_addr == (VEC_ADDR | 1)));

    // R3, R10: a detected edge always leaves the flag set
    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> csr_rdata[3]);

    // R7: in level mode a low pin keeps the flag set
    assert_level_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && csr_rdata[3] && !pin_level) |=> csr_rdata[3]);

    // R4: in edge mode an acknowledge without a new edge clears the flag
    assert_edge_ack_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && csr_rdata[3] && ack_any && !fall) |=> !csr_rdata[3]);

    // R6: a vector fetch clears the flag in edge mode
    assert_fetch_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_hit && !mode && csr_rdata[3] && !fall) |=> !csr_rdata[3]);

    // R11: the request only reaches the priority logic when pending and unmasked
    assert_mask_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (csr_rdata[3] && !csr_rdata[1]));

endmodule

bind ext_irq_ctrl eic_checker #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .csr_rdata (csr_rdata),
    .irq_req   (irq_req),
    .pin_level (pin_level),
    .mode      (mode_q),
    .ack_any   (ack_any),
    .fall      (pin_fall),
    .cpu_rd    (cpu_rd),
    .cpu_addr  (cpu_addr)
);

// File: tb/sim_ext_irq_ctrl.sv
module sim_ext_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              irq_pin_n = 1'b1;
    logic              csr_wr = 1'b0;
    logic [3:0]        csr_wdata = '0;
    logic [3:0]        csr_rdata;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic              cpu_rd = 1'b0;
    logic              irq_req;
    logic              pin_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin_n (irq_pin_n),
        .csr_wr    (csr_wr),
        .csr_wdata (csr_wdata),
        .csr_rdata (csr_rdata),
        .cpu_addr  (cpu_addr),
        .cpu_rd    (cpu_rd),
        .irq_req   (irq_req),
        .pin_level (pin_level)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(logic [3:0] d);
        csr_wr = 1'b1; csr_wdata = d;
        step(1);
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic fetch(logic [15:0] a);
        cpu_rd = 1'b1; cpu_addr = a;
        step(1);
        cpu_rd = 1'b0; cpu_addr = '0;
    endtask

    task automatic clean();
        irq_pin_n = 1'b1;
        step(3);
        csr_write(4'b0100);
    endtask

    task automatic t_reset();
        step(3);
        chk("R1", "rdata in reset", 16'(csr_rdata), 16'h0);
        chk("R1", "irq in reset", 16'(irq_req), 16'h0);
        chk("R2", "level in reset", 16'(pin_level), 16'h1);
        rst_n = 1'b1;
        step(4);
        chk("R1", "rdata after reset", 16'(csr_rdata), 16'h0);
        chk("R1", "irq after reset", 16'(irq_req), 16'h0);
    endtask

    task automatic t_edge();
        irq_pin_n = 1'b0;
        step(1);
        chk("R2", "level one edge", 16'(pin_level), 16'h1);
        step(1);
        chk("R2", "level two edges", 16'(pin_level), 16'h0);
        chk("R3", "flag before set", 16'(csr_rdata[3]), 16'h0);
        step(1);
        chk("R3", "flag set", 16'(csr_rdata[3]), 16'h1);
        chk("R3", "irq set", 16'(irq_req), 16'h1);
        csr_write(4'b0100);
        chk("R4", "flag after ack, pin low", 16'(csr_rdata[3]), 16'h0);
        chk("R4", "irq after ack", 16'(irq_req), 16'h0);
        step(4);
        chk("R4", "no reset by low pin", 16'(csr_rdata[3]), 16'h0);
        irq_pin_n = 1'b1;
        step(1);
        chk("R2", "level rise one edge", 16'(pin_level), 16'h0);
        step(1);
        chk("R2", "level rise two edges", 16'(pin_level), 16'h1);
        clean();
    endtask

    task automatic t_reedge();
        irq_pin_n = 1'b0; step(3);
        csr_write(4'b0100);
        chk("R9", "cleared", 16'(csr_rdata[3]), 16'h0);
        irq_pin_n = 1'b1; step(3);
        irq_pin_n = 1'b0; step(3);
        chk("R9", "new edge sets again", 16'(csr_rdata[3]), 16'h1);
        clean();
    endtask

    task automatic t_regmap();
        csr_write(4'b1011);
        chk("R12", "flag bit write ignored", 16'(csr_rdata), 16'h3);
        csr_write(4'b0111);
        chk("R5", "ack reads 0, mask/mode written", 16'(csr_rdata), 16'h3);
        csr_write(4'b0000);
        chk("R12", "cleared", 16'(csr_rdata), 16'h0);
    endtask

    task automatic t_vector();
        irq_pin_n = 1'b0; step(3);
        fetch(16'hFFF9);
        chk("R6", "FFF9 no ack", 16'(csr_rdata[3]), 16'h1);
        fetch(16'hFFFC);
        chk("R6", "FFFC no ack", 16'(csr_rdata[3]), 16'h1);
        cpu_addr = 16'hFFFA; step(1); cpu_addr = '0;
        chk("R6", "no strobe no ack", 16'(csr_rdata[3]), 16'h1);
        fetch(16'hFFFB);
        chk("R6", "FFFB ack", 16'(csr_rdata[3]), 16'h0);
        irq_pin_n = 1'b1; step(3);
        irq_pin_n = 1'b0; step(3);
        fetch(16'hFFFA);
        chk("R6", "FFFA ack", 16'(csr_rdata[3]), 16'h0);
        clean();
    endtask

    task automatic t_collision();
        irq_pin_n = 1'b0; step(3);
        irq_pin_n = 1'b1; step(3);
        chk("R10", "pending before collision", 16'(csr_rdata[3]), 16'h1);
        irq_pin_n = 1'b0; step(2);
        csr_write(4'b0100);
        chk("R10", "edge wins over ack", 16'(csr_rdata[3]), 16'h1);
        csr_write(4'b0100);
        chk("R4", "second ack clears", 16'(csr_rdata[3]), 16'h0);
        clean();
    endtask

    task automatic t_level_hold();
        csr_write(4'b0001);
        irq_pin_n = 1'b0; step(3);
        chk("R7", "level set", 16'(csr_rdata[3]), 16'h1);
        csr_write(4'b0101);
        chk("R7", "held after ack", 16'(csr_rdata[3]), 16'h1);
        step(5);
        chk("R7", "still held", 16'(csr_rdata[3]), 16'h1);
        irq_pin_n = 1'b1; step(2);
        chk("R7", "held until sync high", 16'(csr_rdata[3]), 16'h1);
        step(1);
        chk("R7", "released", 16'(csr_rdata[3]), 16'h0);
    endtask

    task automatic t_level_noack();
        csr_write(4'b0001);
        irq_pin_n = 1'b0; step(3);
        irq_pin_n = 1'b1; step(5);
        chk("R8", "kept without ack", 16'(csr_rdata[3]), 16'h1);
        csr_write(4'b0101);
        chk("R8", "ack with pin high clears", 16'(csr_rdata[3]), 16'h0);
        clean();
    endtask

    task automatic t_mask();
        csr_write(4'b0010);
        irq_pin_n = 1'b0; step(3);
        chk("R11", "flag set while masked", 16'(csr_rdata[3]), 16'h1);
        chk("R11", "irq masked", 16'(irq_req), 16'h0);
        csr_write(4'b0000);
        chk("R11", "irq after unmask", 16'(irq_req), 16'h1);
        clean();
    endtask

    task automatic t_level_set();
        irq_pin_n = 1'b0; step(3);
        csr_write(4'b0100);
        step(2);
        chk("R13", "idle with pin low", 16'(csr_rdata[3]), 16'h0);
        csr_write(4'b0001);
        chk("R13", "not yet set", 16'(csr_rdata[3]), 16'h0);
        step(1);
        chk("R13", "set by low level", 16'(csr_rdata[3]), 16'h1);
        csr_write(4'b0101);
        irq_pin_n = 1'b1; step(3);
        chk("R7", "released after high", 16'(csr_rdata[3]), 16'h0);
        clean();
    endtask

    task automatic t_reset_low();
        csr_write(4'b0011);
        irq_pin_n = 1'b0; step(3);
        rst_n = 1'b0;
        step(1);
        chk("R1", "reset clears with pin low", 16'(csr_rdata), 16'h0);
        chk("R1", "irq in reset", 16'(irq_req), 16'h0);
        rst_n = 1'b1;
        step(6);
        chk("R1", "no request after reset, pin low", 16'(csr_rdata), 16'h0);
        chk("R2", "level low after reset", 16'(pin_level), 16'h0);
        irq_pin_n = 1'b1; step(3);
        irq_pin_n = 1'b0; step(3);
        chk("R3", "edge after reset sets", 16'(csr_rdata[3]), 16'h1);
        clean();
    endtask

    initial begin
        t_reset();
        t_edge();
        t_reedge();
        t_regmap();
        t_vector();
        t_collision();
        t_level_hold();
        t_level_noack();
        t_mask();
        t_level_set();
        t_reset_low();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule